// File: doc/BRIEF.md
# Saturating Bounded Up/Down Counter

This block keeps a small unsigned count that moves one step at a time under two request inputs: one asks for a step upward, the other for a step downward. The count lives between zero and an upper limit (twenty by default, which is not a power of two). It clamps at either limit and never wraps around. When both requests arrive in the same cycle, the upward request wins. A synchronous reset returns the count to zero.

Each request is sampled on every rising clock edge, so a request held high for several cycles moves the count by one step per cycle until a limit stops it. The block is meant to sit behind logic that has already cleaned and shaped the request inputs. Its output feeds whatever displays or uses the value.

Top module: `updn_sat_counter`

## Requirements
- R1: When rst is 1 at a rising clock edge, count is 0 after that edge, whatever its previous value and whatever the requests are.
- R2: With rst 0, upReq 1 and count below the upper limit (20), count rises by exactly one at the edge.
- R3: With rst 0, upReq 0, downReq 1 and count above 0, count falls by exactly one at the edge.
- R4: With rst 0 and both requests 0, count keeps its value.
- R5: With rst 0 and both requests 1, the upward request has priority: below the limit count rises by one, and it never falls.
- R6: With rst 0, upReq 1 and count equal to 20, count stays at 20 whether downReq is 0 or 1. It never wraps to 0.
- R7: With rst 0, upReq 0, downReq 1 and count equal to 0, count stays at 0. It never wraps to 31 or 20.
- R8: After reset, count never leaves the range 0 to 20.
- R9: A request held high for N consecutive cycles moves count by min(N, distance to the limit) steps, one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, overrides both requests |
| upReq | input | 1 | Request to step the count up by one |
| downReq | input | 1 | Request to step the count down by one; ignored while upReq is 1 |
| count | output | WIDTH (5) | Current count, 0 to MAX_VALUE |

## Verification
The bench builds the counter with its default values: a 5-bit count and an upper limit of 20. With these values, a run of 25 held up-requests climbs all the way to the ceiling and then pushes against it. A wrap at the top would show up as 0 and one at the bottom as 31 or 20, so both are visible. Because 20 sits well below 31, an off-by-one or power-of-two bound check would show up as an out-of-range value. Pseudo-random request patterns pass through both limits many times, and a scoreboard compares every cycle with a reference model.

// File: rtl/updn_pkg.sv
package updn_pkg;

  // Strobes sent from the control module to the datapath module.
  // At most one strobe is active in any cycle.
  typedef struct packed {
    logic clear;
    logic stepUp;
    logic stepDown;
  } ctrlStrobe_t;

  localparam ctrlStrobe_t STROBE_IDLE = '{clear: 1'b0, stepUp: 1'b0, stepDown: 1'b0};

endpackage

// File: rtl/updn_control.sv
module updn_control
  import updn_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        upReq,
  input  logic        downReq,
  input  logic        atTop,
  input  logic        atFloor,
  output ctrlStrobe_t strobe
);

  // Priority order: reset, then up, then down. A request that would
  // cross a limit produces no strobe, so the datapath holds its value.
  always_comb begin
    strobe = STROBE_IDLE;
    if (rst) begin
      strobe.clear = 1'b1;
    end else if (upReq) begin
      strobe.stepUp = !atTop;
    end else if (downReq) begin
      strobe.stepDown = !atFloor;
    end
  end

  // R5: up priority means a down strobe never appears with upReq set.
  p_up_wins_r5: assert property (@(posedge clk) disable iff (rst)
    upReq |-> !strobe.stepDown);

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));

endmodule

// File: rtl/updn_datapath.sv
module updn_datapath
  import updn_pkg::*;
#(
  parameter int WIDTH     = 5,
  parameter int MAX_VALUE = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upReq,
  input  logic             downReq,
  input  ctrlStrobe_t      strobe,
  output logic             atTop,
  output logic             atFloor,
  output logic [WIDTH-1:0] count
);

  localparam logic [WIDTH-1:0] TOP_CNT  = WIDTH'(MAX_VALUE);
  localparam logic [WIDTH-1:0] ZERO_CNT = '0;
  localparam logic [WIDTH-1:0] ONE_CNT  = WIDTH'(1);

  logic [WIDTH-1:0] countReg;
  logic [WIDTH-1:0] incValue;
  logic [WIDTH-1:0] decValue;
  logic [WIDTH-1:0] nextValue;

  // Bound comparators; >= keeps the ceiling closed even from an illegal value.
  assign atTop   = (countReg >= TOP_CNT);
  assign atFloor = (countReg == ZERO_CNT);

  assign incValue = countReg + ONE_CNT;
  assign decValue = countReg - ONE_CNT;

  always_comb begin
    nextValue = countReg;
    if (strobe.clear)         nextValue = ZERO_CNT;
    else if (strobe.stepUp)   nextValue = incValue;
    else if (strobe.stepDown) nextValue = decValue;
  end

  always_ff @(posedge clk) begin
    countReg <= nextValue;
  end

  assign count = countReg;

  // R1: synchronous clear
  p_clear_r1: assert property (@(posedge clk)
    rst |=> (count == ZERO_CNT));

  // R2: single step upward below the ceiling
  p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
    (upReq && count < TOP_CNT) |=> (count == $past(count) + ONE_CNT));

  // R3: single step downward above the floor
  p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
    (!upReq && downReq && count != ZERO_CNT) |=> (count == $past(count) - ONE_CNT));

  // R4: idle holds
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!upReq && !downReq) |=> $stable(count));

  // R5: both requests below the ceiling step upward
  p_both_up_r5: assert property (@(posedge clk) disable iff (rst)
    (upReq && downReq && count < TOP_CNT) |=> (count == $past(count) + ONE_CNT));

  // R6: ceiling holds under any up request
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (upReq && count == TOP_CNT) |=> (count == TOP_CNT));

  // R7: floor holds under a down request
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    (!upReq && downReq && count == ZERO_CNT) |=> (count == ZERO_CNT));

  // R8: range invariant
  p_in_range_r8: assert property (@(posedge clk) disable iff (rst)
    count <= TOP_CNT);

endmodule

// File: rtl/updn_sat_counter.sv
module updn_sat_counter
  import updn_pkg::*;
#(
  parameter int WIDTH     = 5,
  parameter int MAX_VALUE = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upReq,
  input  logic             downReq,
  output logic [WIDTH-1:0] count
);

  ctrlStrobe_t strobe;
  logic        atTop;
  logic        atFloor;

  updn_control u_control (
    .clk     (clk),
    .rst     (rst),
    .upReq   (upReq),
    .downReq (downReq),
    .atTop   (atTop),
    .atFloor (atFloor),
    .strobe  (strobe)
  );

  updn_datapath #(
    .WIDTH     (WIDTH),
    .MAX_VALUE (MAX_VALUE)
  ) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .upReq   (upReq),
    .downReq (downReq),
    .strobe  (strobe),
    .atTop   (atTop),
    .atFloor (atFloor),
    .count   (count)
  );

endmodule

// File: tb/tb_updn_sat_counter.sv
`timescale 1ns/100ps
module tb_updn_sat_counter;

  localparam int WIDTH = 5;
  localparam int TOP   = 20;

  typedef struct {
    logic [WIDTH-1:0] expVal;
    string            tag;
  } scoreItem_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             upReq = 1'b0;
  logic             downReq = 1'b0;
  logic [WIDTH-1:0] count;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int model = 0;
  scoreItem_t scoreQ[$];

  always #2.5 clk = ~clk;

  updn_sat_counter #(.WIDTH(WIDTH), .MAX_VALUE(TOP)) dut (
    .clk     (clk),
    .rst     (rst),
    .upReq   (upReq),
    .downReq (downReq),
    .count   (count)
  );

  // Driver: sets inputs on the falling edge and pushes the value expected
  // after the next rising edge.
  task automatic drive(input logic r, input logic u, input logic d, input string tag);
    scoreItem_t item;
    @(negedge clk);
    rst = r; upReq = u; downReq = d;
    if (r)      model = 0;
    else if (u) model = (model < TOP) ? model + 1 : model;
    else if (d) model = (model > 0) ? model - 1 : model;
    item.expVal = WIDTH'(model);
    item.tag    = tag;
    scoreQ.push_back(item);
  endtask

  task automatic repeatDrive(input int n, input logic r, input logic u, input logic d, input string tag);
    for (int i = 0; i < n; i++) drive(r, u, d, tag);
  endtask

  // Monitor: compares one queued item per rising edge, shortly after it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (scoreQ.size() > 0) begin
        scoreItem_t item;
        item = scoreQ.pop_front();
        checks++;
        if (count !== item.expVal) begin
          failures++;
          $display("FAIL %s: count=%0d expected=%0d", item.tag, count, item.expVal);
        end
        checks++;
        if (!(count <= WIDTH'(TOP))) begin
          failures++;
          $display("FAIL R8: count=%0d expected<=%0d", count, TOP);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr = 8'hA5;
    // R1: reset overrides both requests
    repeatDrive(2, 1'b1, 1'b1, 1'b1, "R1");
    // R4: idle holds at zero
    repeatDrive(3, 1'b0, 1'b0, 1'b0, "R4");
    // R7: down at the floor stays at zero
    repeatDrive(3, 1'b0, 1'b0, 1'b1, "R7");
    // R2: single up pulses
    for (int i = 0; i < 5; i++) begin
      drive(1'b0, 1'b1, 1'b0, "R2");
      drive(1'b0, 1'b0, 1'b0, "R4");
    end
    // R3: down steps
    repeatDrive(2, 1'b0, 1'b0, 1'b1, "R3");
    // R5: both requests step upward
    repeatDrive(3, 1'b0, 1'b1, 1'b1, "R5");
    // R9: held up climbs to the ceiling, then R6 holds there
    repeatDrive(14, 1'b0, 1'b1, 1'b0, "R9");
    repeatDrive(11, 1'b0, 1'b1, 1'b0, "R6");
    // R6: both requests at the ceiling still hold
    repeatDrive(3, 1'b0, 1'b1, 1'b1, "R6");
    repeatDrive(2, 1'b0, 1'b0, 1'b0, "R4");
    // R9: held down falls to the floor, then R7 holds there
    repeatDrive(20, 1'b0, 1'b0, 1'b1, "R9");
    repeatDrive(5, 1'b0, 1'b0, 1'b1, "R7");
    // R1: reset from a mid value
    repeatDrive(7, 1'b0, 1'b1, 1'b0, "R2");
    drive(1'b1, 1'b0, 1'b1, "R1");
    drive(1'b0, 1'b0, 1'b0, "R4");
    // R8: pseudo-random request patterns, biased toward sustained runs
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      drive(1'b0, lfsr[0] & (i % 120 < 60 || lfsr[3]), lfsr[1] | (i % 120 >= 60), "R8");
    end
    drive(1'b1, 1'b1, 1'b0, "R1");
    @(negedge clk);
    rst = 1'b0; upReq = 1'b0; downReq = 1'b0;
    while (scoreQ.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule